// File: doc/BRIEF.md
# Cache tag flush and cacheability controller

This block sits beside a small instruction cache that fronts a serial flash. Software programs it through a 32-bit register bus. It holds the way count, the line size and the length of the flash window that may be cached. For every fetch address it reports whether that address may be served by the cache.

Setting the flush bit starts a walk over the tag RAM. The walk writes one tag index per clock, and each write stores an entry with its valid bit cleared. The walk lasts one cycle per tag entry, and the number of entries follows from the data RAM size parameter: 256 cycles for 8 KB and 512 cycles for 16 KB. While the walk runs, a busy output stalls lookups and the cacheable output is held low, so stale tags can never produce a hit.

Top module: `cache_ctl_top`

## Requirements
- R1: After reset, the way-count field reads 2 (4-way), the line-size field reads 0 (8 bytes), the window length and the extra-region flag read 0, and busy, tag write and cacheable are all low.
- R2: Register map, 32-bit data. The line-size field is bits [1:0] at offset 0x04, with 0=8 B, 1=16 B and 2=32 B. The way-count field is bits [1:0] at offset 0x08, with 0=direct, 1=2-way and 2=4-way. At offset 0x20 the window length N is bits [8:0] and the extra-region-cached flag is bit 11. Every other bit and every unmapped offset reads 0.
- R3: The flush bit is bit 0 at offset 0x00, and it always reads back as 0.
- R4: A write of 1 to the flush bit raises busy and tag write from the next clock edge. The tag index starts at 0 and rises by one on each following clock.
- R5: A flush holds busy high for exactly 32×DATA_KB cycles, which is 256 cycles at the default of 8 KB. Busy then falls.
- R6: A flush request that arrives while a flush is running restarts the walk at index 0, and the full length is counted again from that point.
- R7: Writing the reserved value 3 to the way-count field or to the line-size field leaves that field unchanged.
- R8: An address is cacheable when FLASH_BASE ≤ addr < FLASH_BASE + (N+1)×64 KB.
- R9: When N=0, no address is cacheable.
- R10: When the extra-region flag is set, N is clamped to 255, so the window is at most 16 MB.
- R11: While busy is high, cacheable is low.
- R12: A write of 0 to the flush bit does not start a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| fetch_addr_i | input | 32 | Fetch address to classify |
| cacheable_o | output | 1 | Fetch address may be served by the cache |
| assoc_o | output | 2 | Way-count setting |
| line_size_o | output | 2 | Line-size setting |
| busy_o | output | 1 | Flush running; lookups must stall |
| tag_we_o | output | 1 | Tag RAM write enable (stores an invalid entry) |
| tag_idx_o | output | $clog2(32×DATA_KB) | Tag RAM index being invalidated |

## Verification
Embedded properties check on every cycle that the walk index steps by one, that a request rewinds it to 0, that the walk ends after the last index, that reserved way or line values never land in the registers, and that nothing is cacheable while busy or while N is 0. The exact window bounds, the 16 MB clamp, the total flush length counted from the write, and the register readback are shown only by the bench. It does this with directed edge addresses and seeded random sweeps of N, the flag and the fetch address, compared against a reference function.

// File: rtl/cache_ctl_pkg.sv
package cache_ctl_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_LINE  = 8'h04;
  localparam logic [7:0] OFS_ASSOC = 8'h08;
  localparam logic [7:0] OFS_WIN   = 8'h20;

  localparam int LEN_W       = 9;
  localparam int XREG_BIT    = 11;
  localparam int CLAMP_LEN   = 255;

  typedef enum logic [1:0] {
    WAYS_1    = 2'd0,
    WAYS_2    = 2'd1,
    WAYS_4    = 2'd2,
    WAYS_RSVD = 2'd3
  } ways_e;

  typedef enum logic [1:0] {
    LINE_8B   = 2'd0,
    LINE_16B  = 2'd1,
    LINE_32B  = 2'd2,
    LINE_RSVD = 2'd3
  } line_e;

  typedef struct packed {
    ways_e              ways;
    line_e              line;
    logic [LEN_W-1:0]   win_len;
    logic               xreg_en;
  } cfg_t;
endpackage

// File: rtl/cache_ctl_regs.sv
module cache_ctl_regs
  import cache_ctl_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        flush_req_o,
  output cfg_t        cfg_o
);
  cfg_t cfg_q;

  logic wr_ctrl, wr_line, wr_ways, wr_win;
  assign wr_ctrl = we_i && (addr_i == OFS_CTRL);
  assign wr_line = we_i && (addr_i == OFS_LINE);
  assign wr_ways = we_i && (addr_i == OFS_ASSOC);
  assign wr_win  = we_i && (addr_i == OFS_WIN);

  assign flush_req_o = wr_ctrl && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q.ways    <= WAYS_4;
      cfg_q.line    <= LINE_8B;
      cfg_q.win_len <= '0;
      cfg_q.xreg_en <= 1'b0;
    end else begin
      // reserved encodings are dropped
      if (wr_ways && (wdata_i[1:0] != WAYS_RSVD)) cfg_q.ways <= ways_e'(wdata_i[1:0]);
      if (wr_line && (wdata_i[1:0] != LINE_RSVD)) cfg_q.line <= line_e'(wdata_i[1:0]);
      if (wr_win) begin
        cfg_q.win_len <= wdata_i[LEN_W-1:0];
        cfg_q.xreg_en <= wdata_i[XREG_BIT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      OFS_LINE:  rdata_o[1:0] = cfg_q.line;
      OFS_ASSOC: rdata_o[1:0] = cfg_q.ways;
      OFS_WIN: begin
        rdata_o[LEN_W-1:0] = cfg_q.win_len;
        rdata_o[XREG_BIT]  = cfg_q.xreg_en;
      end
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o = cfg_q;

  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[31:XREG_BIT+1], wdata_i[XREG_BIT-1:LEN_W]};

  // R7
  reserved_ways_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ways && wdata_i[1:0] == 2'd3) |=> $stable(cfg_o.ways));
  // R7
  reserved_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_line && wdata_i[1:0] == 2'd3) |=> $stable(cfg_o.line));
endmodule

// File: rtl/cache_ctl_flush.sv
module cache_ctl_flush #(
  parameter int DATA_KB = 8,
  localparam int STEPS  = DATA_KB * 32,
  localparam int IDX_W  = $clog2(STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  output logic             busy_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(STEPS - 1);

  logic             busy_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (req_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign busy_o = busy_q;
  assign idx_o  = idx_q;

  // R4
  walk_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_i && idx_o != LAST) |=> (busy_o && idx_o == $past(idx_o) + IDX_W'(1)));
  // R6
  walk_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (busy_o && idx_o == '0));
  // R5
  walk_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !req_i && idx_o == LAST) |=> !busy_o);
  // R12
  no_spurious_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !req_i) |=> !busy_o);
endmodule

// File: rtl/cache_ctl_window.sv
module cache_ctl_window
  import cache_ctl_pkg::*;
#(
  parameter logic [31:0] FLASH_BASE = 32'h1600_0000
) (
  input  logic [31:0]      addr_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             xreg_en_i,
  input  logic             block_i,
  output logic             hit_o
);
  logic [LEN_W-1:0] eff_len;
  logic [LEN_W:0]   blocks;
  logic [31:0]      ofs;

  always_comb begin
    eff_len = len_i;
    if (xreg_en_i && (len_i > LEN_W'(CLAMP_LEN))) eff_len = LEN_W'(CLAMP_LEN);
    blocks = {1'b0, eff_len} + (LEN_W+1)'(1);
    ofs    = addr_i - FLASH_BASE;
    hit_o  = (len_i != '0) && !block_i && (addr_i >= FLASH_BASE) &&
             (ofs[31:16] < {{(16-LEN_W-1){1'b0}}, blocks});
  end

  logic unused_ofs;
  assign unused_ofs = ^ofs[15:0];
endmodule

// File: rtl/cache_ctl_top.sv
module cache_ctl_top
  import cache_ctl_pkg::*;
#(
  parameter int          DATA_KB    = 8,
  parameter logic [31:0] FLASH_BASE = 32'h1600_0000
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          reg_we_i,
  input  logic [7:0]                    reg_addr_i,
  input  logic [31:0]                   reg_wdata_i,
  output logic [31:0]                   reg_rdata_o,
  input  logic [31:0]                   fetch_addr_i,
  output logic                          cacheable_o,
  output logic [1:0]                    assoc_o,
  output logic [1:0]                    line_size_o,
  output logic                          busy_o,
  output logic                          tag_we_o,
  output logic [$clog2(DATA_KB*32)-1:0] tag_idx_o
);
  localparam int IDX_W = $clog2(DATA_KB * 32);

  cfg_t             cfg;
  logic             flush_req;
  logic             busy;
  logic [IDX_W-1:0] idx;

  cache_ctl_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .flush_req_o (flush_req),
    .cfg_o       (cfg)
  );

  cache_ctl_flush #(.DATA_KB(DATA_KB)) u_flush (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (flush_req),
    .busy_o (busy),
    .idx_o  (idx)
  );

  cache_ctl_window #(.FLASH_BASE(FLASH_BASE)) u_win (
    .addr_i    (fetch_addr_i),
    .len_i     (cfg.win_len),
    .xreg_en_i (cfg.xreg_en),
    .block_i   (busy),
    .hit_o     (cacheable_o)
  );

  assign assoc_o     = cfg.ways;
  assign line_size_o = cfg.line;
  assign busy_o      = busy;
  assign tag_we_o    = busy;
  assign tag_idx_o   = idx;

  // R11
  busy_blocks_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cacheable_o);
  // R9
  zero_len_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.win_len == '0) |-> !cacheable_o);
  // R10
  clamp_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.xreg_en && cacheable_o) |-> (fetch_addr_i - FLASH_BASE < 32'h0100_0000));
endmodule

// File: tb/cache_ctl_top_tb.sv
module cache_ctl_top_tb;
  localparam int          CLK_NS = 10;
  localparam logic [31:0] BASE   = 32'h1600_0000;
  localparam int          STEPS  = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [31:0] faddr = '0;
  logic        cach;
  logic [1:0]  ways, line;
  logic        busy, twe;
  logic [7:0]  tidx;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  cache_ctl_top #(.DATA_KB(8), .FLASH_BASE(BASE)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fetch_addr_i(faddr),
    .cacheable_o(cach), .assoc_o(ways), .line_size_o(line),
    .busy_o(busy), .tag_we_o(twe), .tag_idx_o(tidx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  function automatic logic exp_hit(input logic [31:0] a, input int n, input logic xf);
    int eff;
    logic [31:0] ofs;
    if (n == 0) return 1'b0;
    eff = (xf && n > 255) ? 255 : n;
    if (a < BASE) return 1'b0;
    ofs = a - BASE;
    return (ofs >> 16) < (eff + 1);
  endfunction

  task automatic probe(input string req, input logic [31:0] a, input int n, input logic xf);
    faddr = a;
    #1 chk(req, {31'b0, cach}, {31'b0, exp_hit(a, n, xf)});
  endtask

  task automatic set_win(input int n, input logic xf);
    wr(8'h20, (32'(xf) << 11) | 32'(n));
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 ways", {30'b0, ways}, 32'd2);
    chk("R1 line", {30'b0, line}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 twe", {31'b0, twe}, 32'd0);
    rd(8'h20, d); chk("R1 win reg", d, 32'd0);
    probe("R1 cacheable", BASE, 0, 1'b0);

    // R2 register map
    wr(8'h04, 32'hFFFF_FFF2); rd(8'h04, d); chk("R2 line rd", d, 32'd2);
    chk("R2 line port", {30'b0, line}, 32'd2);
    wr(8'h08, 32'h0000_0001); rd(8'h08, d); chk("R2 ways rd", d, 32'd1);
    wr(8'h20, 32'hFFFF_FFFF); rd(8'h20, d); chk("R2 win rd", d, 32'h0000_09FF);
    rd(8'h10, d); chk("R2 unmapped", d, 32'd0);
    wr(8'h04, 32'd1); rd(8'h04, d); chk("R2 line 16B", d, 32'd1);

    // R7 reserved values ignored
    wr(8'h08, 32'd3); rd(8'h08, d); chk("R7 ways rsvd", d, 32'd1);
    wr(8'h04, 32'd3); rd(8'h04, d); chk("R7 line rsvd", d, 32'd1);
    chk("R7 line port", {30'b0, line}, 32'd1);

    // R3 / R12
    wr(8'h00, 32'd0);
    chk("R12 no start", {31'b0, busy}, 32'd0);
    rd(8'h00, d); chk("R3 ctrl rd idle", d, 32'd0);

    // R8 / R9 / R10 directed edges
    set_win(0, 1'b0);
    probe("R9 n0", BASE, 0, 1'b0);
    set_win(3, 1'b0);
    probe("R8 last byte", BASE + 32'h0004_0000 - 1, 3, 1'b0);
    probe("R8 first out", BASE + 32'h0004_0000, 3, 1'b0);
    probe("R8 below base", BASE - 1, 3, 1'b0);
    probe("R8 base", BASE, 3, 1'b0);
    set_win(300, 1'b1);
    probe("R10 clamp in", BASE + 32'h0100_0000 - 1, 300, 1'b1);
    probe("R10 clamp out", BASE + 32'h0100_0000, 300, 1'b1);
    set_win(300, 1'b0);
    probe("R10 no clamp", BASE + 32'h0100_0000, 300, 1'b0);
    set_win(511, 1'b0);
    probe("R8 max in", BASE + 32'h0200_0000 - 1, 511, 1'b0);
    probe("R8 max out", BASE + 32'h0200_0000, 511, 1'b0);

    // R8 / R10 random sweep
    for (int i = 0; i < 150; i++) begin
      int n = int'($urandom % 512);
      logic xf = 1'($urandom);
      set_win(n, xf);
      for (int j = 0; j < 3; j++) begin
        logic [31:0] a;
        if ($urandom % 4 == 0) a = BASE - 1 - ($urandom % 32'h0001_0000);
        else a = BASE + ($urandom % 32'h0220_0000);
        probe("R8 random", a, n, xf);
      end
    end

    // R4 / R5 / R11 flush walk
    set_win(4, 1'b0);
    faddr = BASE + 32'h100;
    wr(8'h00, 32'd1);
    rd(8'h00, d); chk("R3 ctrl rd busy", d, 32'd0);
    for (int k = 0; k < STEPS; k++) begin
      if (k == 0 || k == 1 || k == 100 || k == STEPS - 1) begin
        chk("R4 busy", {31'b0, busy}, 32'd1);
        chk("R4 twe", {31'b0, twe}, 32'd1);
        chk("R4 idx", {24'b0, tidx}, 32'(k));
        chk("R11 blocked", {31'b0, cach}, 32'd0);
      end else if (busy !== 1'b1 || tidx !== 8'(k) || cach !== 1'b0) begin
        chk("R5 walk", {23'b0, busy, tidx}, {23'b1, 8'(k)});
      end
      @(negedge clk);
    end
    #1;
    chk("R5 done", {31'b0, busy}, 32'd0);
    chk("R5 twe off", {31'b0, twe}, 32'd0);
    chk("R11 released", {31'b0, cach}, 32'd1);

    // R6 restart during flush
    wr(8'h00, 32'd1);
    repeat (10) @(negedge clk);
    chk("R6 pre idx", {24'b0, tidx}, 32'd10);
    wr(8'h00, 32'd1);
    chk("R6 restart idx", {24'b0, tidx}, 32'd0);
    chk("R6 busy", {31'b0, busy}, 32'd1);
    repeat (STEPS - 1) @(negedge clk);
    chk("R6 still busy", {31'b0, busy}, 32'd1);
    chk("R6 last idx", {24'b0, tidx}, 32'(STEPS - 1));
    @(negedge clk);
    chk("R6 end", {31'b0, busy}, 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule